// File: doc/BRIEF.md
# Composite Sync Level Inserter

This block sits on the three-channel pixel path just before the DAC codes. Each cycle the timing generator hands it a two-bit pulse-kind code for the current pixel. On each channel the block either forwards the incoming video sample or replaces it with a programmed level. The levels are the low sync tip, the high sync level (also used for serration and broad pulses in vertical blanking) and the blanking level. Channel 0 carries luma or green. Channels 1 and 2 carry chroma, and all chroma channels share one set of levels that is separate from the luma set.

Software chooses where sync is inserted: on no channel, on the luma channel alone, or on all three channels. A channel that does not take sync shows its blanking level during sync pulses. A second control covers the active part of vertical-blanking lines that carry no pulse, which the timing generator marks with a quiet-line flag. On those pixels the control either lets video through or forces blanking. Every result leaves the block exactly two clock cycles after its inputs were presented.

Top module: `sync_level_inserter`

## Requirements
- R1: While reset is asserted, and on the first clock edge after it is released, all three outputs are zero.
- R2: A pixel with kind 0 (video) on a line without the quiet flag appears unchanged on each channel exactly two clock edges after it was presented.
- R3: With insertion mode 2 (all channels), kind 2 gives the low sync level and kind 3 gives the high sync level. Channel 0 uses the luma levels and channels 1 and 2 use the chroma levels.
- R4: With insertion mode 1 (luma only), kinds 2 and 3 give the luma low and high levels on channel 0, and the chroma blanking level on channels 1 and 2.
- R5: With insertion mode 0 (none), or the reserved mode 3, kinds 2 and 3 give the blanking level on every channel (luma blanking on channel 0, chroma blanking on the others).
- R6: Kind 1 (blank) gives luma blanking on channel 0 and chroma blanking on channels 1 and 2, whatever the insertion mode.
- R7: On a kind-0 pixel with the quiet flag set, the video sample is output when the pass-through control is 1 and the blanking levels are output when it is 0.
- R8: The quiet flag has no effect on pixels of kinds 1, 2 and 3.
- R9: The insertion mode and pass-through control apply to the pixel presented in the same cycle. Level values apply one cycle later and are held steady while pixels are in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Insertion target: 0 none, 1 luma only, 2 all, 3 reserved (acts as none) |
| cfg_pass_en | input | 1 | Pass video on quiet vertical-blanking lines |
| y_sync_lo | input | 11 | Luma low sync level |
| y_sync_hi | input | 11 | Luma high sync / serration / broad level |
| y_blank | input | 11 | Luma blanking level |
| c_sync_lo | input | 11 | Chroma low sync level |
| c_sync_hi | input | 11 | Chroma high sync / serration / broad level |
| c_blank | input | 11 | Chroma blanking level |
| pix_kind | input | 2 | Pulse kind: 0 video, 1 blank, 2 sync low, 3 sync high |
| vbi_quiet | input | 1 | Pixel lies in the active part of a vertical-blanking line without pulses |
| y_in | input | 11 | Luma / green sample |
| cb_in | input | 11 | First chroma sample |
| cr_in | input | 11 | Second chroma sample |
| y_out | output | 11 | Channel 0 DAC code |
| cb_out | output | 11 | Channel 1 DAC code |
| cr_out | output | 11 | Channel 2 DAC code |

## Verification
The case that is hardest to reach is the one where the quiet-line flag meets each pass-through setting and also meets sync kinds, which must override it. The stimulus runs quiet-flagged pixels of all four kinds with pass-through off and then on. Sync codes are also driven under each of the four insertion modes with all six levels set to distinct values, so a channel that takes the wrong level or the wrong table shows up. Sequences where the kind changes on every pixel check that the two-cycle latency holds from one pixel to the next.

// File: rtl/sli_pkg.sv
package sli_pkg;

    localparam int NCH = 3;

    typedef enum logic [1:0] {
        K_VIDEO = 2'd0,
        K_BLANK = 2'd1,
        K_LOW   = 2'd2,
        K_HIGH  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        M_NONE = 2'd0,
        M_LUMA = 2'd1,
        M_ALL  = 2'd2,
        M_RSVD = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        S_VIDEO = 2'd0,
        S_BLANK = 2'd1,
        S_LOW   = 2'd2,
        S_HIGH  = 2'd3
    } sel_e;

endpackage

// File: rtl/sli_chan_decode.sv
module sli_chan_decode
    import sli_pkg::*;
#(
    parameter bit IS_LUMA = 1'b0
) (
    input  kind_e kind,
    input  logic  quiet,
    input  logic  pass_en,
    input  mode_e mode,
    output sel_e  sel
);

    logic takes_sync;

    always_comb begin
        takes_sync = (mode == M_ALL) || ((mode == M_LUMA) && IS_LUMA);
        unique case (kind)
            K_VIDEO: sel = (quiet && !pass_en) ? S_BLANK : S_VIDEO;
            K_BLANK: sel = S_BLANK;
            K_LOW:   sel = takes_sync ? S_LOW  : S_BLANK;
            K_HIGH:  sel = takes_sync ? S_HIGH : S_BLANK;
            default: sel = S_BLANK;
        endcase
    end

endmodule

// File: rtl/sli_level_pick.sv
module sli_level_pick
    import sli_pkg::*;
#(
    parameter int DW = 11
) (
    input  sel_e          sel,
    input  logic [DW-1:0] video,
    input  logic [DW-1:0] blank_lvl,
    input  logic [DW-1:0] low_lvl,
    input  logic [DW-1:0] high_lvl,
    output logic [DW-1:0] code
);

    always_comb begin
        unique case (sel)
            S_VIDEO: code = video;
            S_BLANK: code = blank_lvl;
            S_LOW:   code = low_lvl;
            S_HIGH:  code = high_lvl;
            default: code = blank_lvl;
        endcase
    end

endmodule

// File: rtl/sync_level_inserter.sv
module sync_level_inserter
    import sli_pkg::*;
#(
    parameter int DW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_pass_en,
    input  logic [DW-1:0] y_sync_lo,
    input  logic [DW-1:0] y_sync_hi,
    input  logic [DW-1:0] y_blank,
    input  logic [DW-1:0] c_sync_lo,
    input  logic [DW-1:0] c_sync_hi,
    input  logic [DW-1:0] c_blank,
    input  logic [1:0]    pix_kind,
    input  logic          vbi_quiet,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] cb_in,
    input  logic [DW-1:0] cr_in,
    output logic [DW-1:0] y_out,
    output logic [DW-1:0] cb_out,
    output logic [DW-1:0] cr_out
);

    localparam int CFGW = 3 + 6 * DW;

    typedef struct packed {
        logic [NCH-1:0][1:0]    sel;
        logic [NCH-1:0][DW-1:0] vid;
    } stage1_t;

    typedef struct packed {
        stage1_t                s1;
        logic [NCH-1:0][DW-1:0] out;
    } state_t;

    state_t st_d, st_q;

    logic [DW-1:0] vin_w   [NCH];
    logic [DW-1:0] blank_w [NCH];
    logic [DW-1:0] lo_w    [NCH];
    logic [DW-1:0] hi_w    [NCH];
    logic [DW-1:0] pick_w  [NCH];
    sel_e          sel_w   [NCH];

    assign vin_w[0] = y_in;
    assign vin_w[1] = cb_in;
    assign vin_w[2] = cr_in;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        if (ch == 0) begin : g_luma
            assign blank_w[ch] = y_blank;
            assign lo_w[ch]    = y_sync_lo;
            assign hi_w[ch]    = y_sync_hi;
        end else begin : g_chroma
            assign blank_w[ch] = c_blank;
            assign lo_w[ch]    = c_sync_lo;
            assign hi_w[ch]    = c_sync_hi;
        end

        sli_chan_decode #(
            .IS_LUMA (ch == 0)
        ) u_decode (
            .kind    (kind_e'(pix_kind)),
            .quiet   (vbi_quiet),
            .pass_en (cfg_pass_en),
            .mode    (mode_e'(cfg_mode)),
            .sel     (sel_w[ch])
        );

        sli_level_pick #(
            .DW (DW)
        ) u_pick (
            .sel       (sel_e'(st_q.s1.sel[ch])),
            .video     (st_q.s1.vid[ch]),
            .blank_lvl (blank_w[ch]),
            .low_lvl   (lo_w[ch]),
            .high_lvl  (hi_w[ch]),
            .code      (pick_w[ch])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int ch = 0; ch < NCH; ch++) begin
            st_d.s1.sel[ch] = sel_w[ch];
            st_d.s1.vid[ch] = vin_w[ch];
            st_d.out[ch]    = pick_w[ch];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_out  = st_q.out[0];
    assign cb_out = st_q.out[1];
    assign cr_out = st_q.out[2];

    // Assertion support: time since reset and configuration history
    logic [1:0]      warm_q;
    logic [CFGW-1:0] cfg_now, cfg_h1_q, cfg_h2_q;
    logic            steady;

    assign cfg_now = {cfg_mode, cfg_pass_en, y_sync_lo, y_sync_hi, y_blank,
                      c_sync_lo, c_sync_hi, c_blank};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q   <= '0;
            cfg_h1_q <= '0;
            cfg_h2_q <= '0;
        end else begin
            if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
            cfg_h1_q <= cfg_now;
            cfg_h2_q <= cfg_h1_q;
        end
    end

    assign steady = (warm_q == 2'd2) && (cfg_now == cfg_h1_q) && (cfg_h1_q == cfg_h2_q);

    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (y_out == '0 && cb_out == '0 && cr_out == '0));

    a_r2_video_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && $past(pix_kind, 2) == 2'd0 && !$past(vbi_quiet, 2))
        |-> (y_out == $past(y_in, 2) && cb_out == $past(cb_in, 2) && cr_out == $past(cr_in, 2)));

    a_r3_all_high: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && cfg_mode == 2'd2 && $past(pix_kind, 2) == 2'd3)
        |-> (y_out == y_sync_hi && cb_out == c_sync_hi && cr_out == c_sync_hi));

    a_r4_luma_low: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && cfg_mode == 2'd1 && $past(pix_kind, 2) == 2'd2)
        |-> (y_out == y_sync_lo && cb_out == c_blank && cr_out == c_blank));

    a_r5_none_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && (cfg_mode == 2'd0 || cfg_mode == 2'd3) && $past(pix_kind, 2) != 2'd0)
        |-> (y_out == y_blank && cb_out == c_blank && cr_out == c_blank));

    a_r7_quiet_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && !cfg_pass_en && $past(pix_kind, 2) == 2'd0 && $past(vbi_quiet, 2))
        |-> (y_out == y_blank && cb_out == c_blank && cr_out == c_blank));

endmodule

// File: tb/sync_level_inserter_bench.sv
`timescale 1ns/1ps
module sync_level_inserter_bench;

    typedef struct {
        logic [10:0] y;
        logic [10:0] cb;
        logic [10:0] cr;
        int          stamp;
        string       req;
    } exp_t;

    exp_t q[$];

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd2;
    logic        cfg_pass_en = 1'b1;
    logic [10:0] y_sync_lo = 11'd16, y_sync_hi = 11'd700, y_blank = 11'd64;
    logic [10:0] c_sync_lo = 11'd200, c_sync_hi = 11'd900, c_blank = 11'd512;
    logic [1:0]  pix_kind = 2'd0;
    logic        vbi_quiet = 1'b0;
    logic [10:0] y_in = 11'd5, cb_in = 11'd6, cr_in = 11'd7;
    logic [10:0] y_out, cb_out, cr_out;

    int cyc = 0;
    int checks = 0;
    int failures = 0;

    sync_level_inserter u_sync_level_inserter (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_pass_en(cfg_pass_en),
        .y_sync_lo(y_sync_lo), .y_sync_hi(y_sync_hi), .y_blank(y_blank),
        .c_sync_lo(c_sync_lo), .c_sync_hi(c_sync_hi), .c_blank(c_blank),
        .pix_kind(pix_kind), .vbi_quiet(vbi_quiet),
        .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in),
        .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, string what, logic [10:0] act, logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [10:0] model(int ch, logic [1:0] kind, logic quiet, logic [10:0] vid);
        logic [10:0] bl, lo, hi;
        logic        tgt;
        bl  = (ch == 0) ? y_blank : c_blank;
        lo  = (ch == 0) ? y_sync_lo : c_sync_lo;
        hi  = (ch == 0) ? y_sync_hi : c_sync_hi;
        tgt = (cfg_mode == 2'd2) || (cfg_mode == 2'd1 && ch == 0);
        if (kind == 2'd1) return bl;
        if (kind == 2'd0) return (quiet && !cfg_pass_en) ? bl : vid;
        if (!tgt) return bl;
        return (kind == 2'd2) ? lo : hi;
    endfunction

    task automatic drive(logic [1:0] kind, logic quiet, string req);
        exp_t e;
        @(negedge clk);
        pix_kind  = kind;
        vbi_quiet = quiet;
        y_in      = 11'($urandom);
        cb_in     = 11'($urandom);
        cr_in     = 11'($urandom);
        e.y     = model(0, kind, quiet, y_in);
        e.cb    = model(1, kind, quiet, cb_in);
        e.cr    = model(2, kind, quiet, cr_in);
        e.stamp = cyc;
        e.req   = req;
        q.push_back(e);
    endtask

    task automatic set_cfg(logic [1:0] mode, logic pass);
        repeat (3) @(negedge clk);
        cfg_mode    = mode;
        cfg_pass_en = pass;
    endtask

    task automatic pattern(string req);
        for (int i = 0; i < 8; i++) drive(2'(i % 4), 1'b0, req);
    endtask

    // Monitor: pops the scoreboard when an item's result is due
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].stamp + 2 == cyc) begin
            exp_t e;
            e = q.pop_front();
            check(e.req, "y_out", y_out, e.y);
            check(e.req, "cb_out", cb_out, e.cb);
            check(e.req, "cr_out", cr_out, e.cr);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset holds outputs at zero even with live video on the inputs
        repeat (3) begin
            @(negedge clk);
            check("R1", "y_out", y_out, 11'd0);
            check("R1", "cb_out", cb_out, 11'd0);
            check("R1", "cr_out", cr_out, 11'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "y_out after release", y_out, 11'd0);
        check("R1", "cr_out after release", cr_out, 11'd0);

        // R2: video passes with two-cycle latency
        set_cfg(2'd2, 1'b1);
        for (int i = 0; i < 20; i++) drive(2'd0, 1'b0, "R2");

        // R3: all-channel insertion, R6 blank codes, every-pixel changes
        pattern("R3");
        for (int i = 0; i < 4; i++) drive(2'd1, 1'b0, "R6");

        // R4: luma-only insertion
        set_cfg(2'd1, 1'b1);
        pattern("R4");

        // R5: no insertion, then reserved mode
        set_cfg(2'd0, 1'b1);
        pattern("R5");
        set_cfg(2'd3, 1'b1);
        pattern("R5");

        // R7 and R8: quiet lines with pass-through off
        set_cfg(2'd2, 1'b0);
        for (int i = 0; i < 4; i++) drive(2'd0, 1'b1, "R7");
        drive(2'd2, 1'b1, "R8");
        drive(2'd3, 1'b1, "R8");
        drive(2'd1, 1'b1, "R8");
        drive(2'd0, 1'b0, "R7");
        drive(2'd0, 1'b1, "R7");

        // R7: quiet lines with pass-through on
        set_cfg(2'd2, 1'b1);
        for (int i = 0; i < 4; i++) drive(2'd0, 1'b1, "R7");
        drive(2'd3, 1'b1, "R8");

        // R9: new level values after a drain, luma-only with quiet sync
        repeat (3) @(negedge clk);
        y_sync_lo = 11'd33;  y_sync_hi = 11'd1800; y_blank = 11'd99;
        c_sync_lo = 11'd400; c_sync_hi = 11'd1500; c_blank = 11'd1024;
        pattern("R9");
        set_cfg(2'd1, 1'b0);
        drive(2'd2, 1'b1, "R8");
        drive(2'd0, 1'b1, "R9");
        pattern("R9");

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule